// File: doc/BRIEF.md
# Synchronous Host Bus Slave Bridge

This block is a clocked slave port that sits on an external microprocessor bus and turns host reads and writes into transactions on a 32-bit internal system bus. The host selects the block with two chip selects of opposite polarity, starts a transfer with an active-low start strobe, and gives the direction on a read/write line. Each beat is closed with a one-cycle active-low acknowledge. If the internal slave fails a beat, a transfer-error pulse is returned instead. If the internal slave asks for the cycle to be repeated, a retry pulse is returned.

The host data port can be set at run time to 8, 16 or 32 bits. Narrow host data always sits in the low bits of the host data bus and is steered onto the byte lanes of the internal word that the low address bits pick. Every host byte lane carries one even-parity bit. Reads generate parity. Write parity errors set a sticky flag that the host can see in a local status byte. A transfer started with the burst line low runs four beats, and the address advances by one port-width step per beat. The host can cut the burst short by raising its burst-in-progress line. An internal interrupt source is passed to an active-low interrupt output.

Top module: `hbus_bridge`

## Requirements
- R1: A transfer starts only when `hb_ts_n` is sampled low while `hb_cs0_n` is low and `hb_cs1` is high. Any other combination causes no internal request and no response pulse.
- R2: For a write, the block raises `sb_req` with `sb_we`=1 and holds it, with a stable address, until the internal slave answers. `sb_addr` is the host address with bits [1:0] cleared. In 8-bit mode (`cfg_width`=0) the byte from `hb_data_i[7:0]` goes to lane `addr[1:0]`, and `sb_be` has only bit `addr[1:0]` set. In 16-bit mode (`cfg_width`=1) `hb_data_i[15:0]` goes to halfword `addr[1]`, and `sb_be` is 4'b0011 or 4'b1100. In 32-bit mode (`cfg_width`=2 or 3) `sb_be` is 4'b1111.
- R3: For a read, the selected lane of `sb_rdata` appears right-aligned on `hb_data_o`, with the unused upper bits zero. `hb_data_oe` is high in the acknowledge cycle.
- R4: Every completed beat drives `hb_ta_n` low for exactly one clock cycle.
- R5: A transfer started with `hb_burst_n` low makes four beats. Each beat's address is the previous one plus 1, 2 or 4 bytes, according to the port width.
- R6: If `hb_bdip_n` is high when the next burst beat would start, the burst ends and no further internal request is issued.
- R7: When `sb_err` answers a request, `hb_tea_n` is low for one cycle and `hb_ta_n` stays high. The transfer ends, including a burst.
- R8: When `sb_retry` answers a request, `hb_rtry_n` is low for one cycle and `hb_ta_n` stays high. The transfer ends.
- R9: During a read acknowledge, `hb_par_o[k]` is the XOR of host byte k for each active lane (k below 1, 2 or 4 bytes). Inactive lanes, and all lanes when `cfg_par_en` is 0, drive 0.
- R10: The word at host address 18'h3FFFC is a local status byte that is repeated in every lane. Its bit0 is a sticky write parity error. That bit is set by a write whose active lanes break even parity while `cfg_par_en` is 1, and it is cleared by a write to the status address with data bit0 = 1. A write with parity checking off never sets the bit.
- R11: `hb_irq_n` equals the inverse of `irq_src` one cycle later. Status bit1 reads the current `irq_src`.
- R12: After reset, `hb_ta_n`, `hb_tea_n`, `hb_rtry_n` and `hb_irq_n` are high, and `sb_req` and `hb_data_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| cfg_width | input | 2 | Host port width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cfg_par_en | input | 1 | Enables parity generation and checking |
| hb_cs0_n | input | 1 | Active-low select |
| hb_cs1 | input | 1 | Active-high select |
| hb_ts_n | input | 1 | Active-low transfer start |
| hb_rw | input | 1 | 1 = read, 0 = write |
| hb_burst_n | input | 1 | Low = four-beat burst |
| hb_bdip_n | input | 1 | Low while further burst beats are wanted |
| hb_addr | input | 18 | Host byte address |
| hb_data_i | input | 32 | Host write data |
| hb_par_i | input | 4 | Host write parity, one bit per byte |
| hb_data_o | output | 32 | Host read data |
| hb_par_o | output | 4 | Host read parity |
| hb_data_oe | output | 1 | Read data valid / drive enable |
| hb_ta_n | output | 1 | Active-low beat acknowledge |
| hb_tea_n | output | 1 | Active-low transfer error |
| hb_rtry_n | output | 1 | Active-low retry request |
| hb_irq_n | output | 1 | Active-low interrupt request |
| irq_src | input | 1 | Internal interrupt source, active high |
| sb_req | output | 1 | Internal bus request |
| sb_we | output | 1 | Internal bus write |
| sb_addr | output | 18 | Internal word-aligned address |
| sb_be | output | 4 | Internal byte enables |
| sb_wdata | output | 32 | Internal write data |
| sb_rdata | input | 32 | Internal read data |
| sb_ack | input | 1 | Internal slave completes the request |
| sb_err | input | 1 | Internal slave reports an error |
| sb_retry | input | 1 | Internal slave asks for a retry |

## Verification
The bench writes bytes and halfwords into different lanes of one word and reads the word back at full width. A design with crossed lane steering would corrupt neighbouring bytes or return the wrong byte on a narrow read. It aborts a burst after two beats and checks the internal request queue. A design that samples the burst-in-progress line late would issue a third request. It also injects internal errors and retries in both single and burst transfers. A design that still acknowledged, or carried on with the burst, would show an extra `hb_ta_n` pulse. Bad write parity is sent with checking both off and on, and the sticky flag is cleared through the status address. A design that checks inactive lanes, or ignores the enable, would leave the wrong flag value.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        W8  = 2'd0,
        W16 = 2'd1,
        W32 = 2'd2
    } wmode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } st_e;

    function automatic wmode_e eff_width(input logic [1:0] cfg);
        case (cfg)
            2'd0:    return W8;
            2'd1:    return W16;
            default: return W32;
        endcase
    endfunction

    function automatic int lane_count(input wmode_e w);
        case (w)
            W8:      return 1;
            W16:     return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/hbus_lanes.sv
module hbus_lanes
    import hbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  wmode_e          width,
    input  logic            par_en,
    input  logic [1:0]      lane_sel,
    input  logic [DW-1:0]   hin,
    output logic [DW-1:0]   sb_wdata,
    output logic [DW/8-1:0] sb_be,
    input  logic [DW-1:0]   sb_rdata,
    output logic [DW-1:0]   host_rd,
    input  logic [DW-1:0]   hd_i,
    input  logic [DW/8-1:0] hp_i,
    output logic            perr_now,
    input  logic [DW-1:0]   hout,
    output logic [DW/8-1:0] hp_o
);
    localparam int NL = DW / 8;

    logic [NL-1:0] lane_bad;
    int            nact;

    assign nact = lane_count(width);

    always_comb begin
        case (width)
            W8: begin
                sb_wdata = {4{hin[7:0]}};
                sb_be    = NL'(1) << lane_sel;
                host_rd  = DW'(sb_rdata[8*lane_sel +: 8]);
            end
            W16: begin
                sb_wdata = {2{hin[15:0]}};
                sb_be    = lane_sel[1] ? 4'b1100 : 4'b0011;
                host_rd  = DW'(sb_rdata[16*lane_sel[1] +: 16]);
            end
            default: begin
                sb_wdata = hin;
                sb_be    = '1;
                host_rd  = sb_rdata;
            end
        endcase
    end

    for (genvar k = 0; k < NL; k++) begin : g_lane
        assign lane_bad[k] = par_en && (k < nact) && ((^hd_i[8*k +: 8]) ^ hp_i[k]);
        assign hp_o[k]     = par_en && (k < nact) && (^hout[8*k +: 8]);
    end

    assign perr_now = |lane_bad;

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int          AW        = 18,
    parameter int          DW        = 32,
    parameter int          BURST_LEN = 4,
    parameter logic [AW-1:0] STAT_ADDR = 18'h3FFFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wmode_e        width,
    input  logic          ts_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          rw,
    input  logic          burst_n,
    input  logic          bdip_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] hd_i,
    input  logic          perr_now,
    input  logic [DW-1:0] host_rd,
    input  logic          irq_src,
    input  logic          sb_ack,
    input  logic          sb_err,
    input  logic          sb_retry,
    output logic          sb_req,
    output logic          sb_we,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] hin_q,
    output logic [DW-1:0] hout_q,
    output logic          ta_n,
    output logic          tea_n,
    output logic          rtry_n,
    output logic          irq_n,
    output logic          oe
);
    localparam int BW = $clog2(BURST_LEN);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic          rd;
        logic          bst;
        logic [BW-1:0] beat;
        logic [DW-1:0] hin;
        logic [DW-1:0] hout;
        logic          ta_n;
        logic          tea_n;
        logic          rtry_n;
        logic          irq_n;
        logic          oe;
        logic          perr;
    } seq_t;

    seq_t          q, d;
    logic          hit;
    logic          clr;
    logic [AW-1:0] step_d;
    logic [7:0]    stat_d;

    assign hit    = (q.addr[AW-1:2] == STAT_ADDR[AW-1:2]);
    assign clr    = hit && !q.rd && hd_i[0];
    assign stat_d = {6'd0, irq_src, q.perr};

    always_comb begin
        case (width)
            W8:      step_d = AW'(1);
            W16:     step_d = AW'(2);
            default: step_d = AW'(4);
        endcase
    end

    always_comb begin
        d        = q;
        d.ta_n   = 1'b1;
        d.tea_n  = 1'b1;
        d.rtry_n = 1'b1;
        d.oe     = 1'b0;
        d.irq_n  = ~irq_src;
        case (q.st)
            S_IDLE: begin
                if (!ts_n && !cs0_n && cs1) begin
                    d.st   = S_ISSUE;
                    d.addr = addr_i;
                    d.rd   = rw;
                    d.bst  = !burst_n;
                    d.beat = '0;
                end
            end
            S_ISSUE: begin
                if (q.beat != '0 && bdip_n) begin
                    d.st = S_IDLE;
                end else begin
                    if (!q.rd) begin
                        d.hin  = hd_i;
                        d.perr = (q.perr && !clr) || perr_now;
                    end
                    if (hit) begin
                        d.st   = S_IDLE;
                        d.ta_n = 1'b0;
                        d.oe   = q.rd;
                        if (q.rd) d.hout = {4{stat_d}};
                    end else begin
                        d.st = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (sb_err) begin
                    d.tea_n = 1'b0;
                    d.st    = S_IDLE;
                end else if (sb_retry) begin
                    d.rtry_n = 1'b0;
                    d.st     = S_IDLE;
                end else if (sb_ack) begin
                    d.ta_n = 1'b0;
                    d.oe   = q.rd;
                    if (q.rd) d.hout = host_rd;
                    if (q.bst && q.beat != BW'(BURST_LEN - 1) && !bdip_n) begin
                        d.st   = S_ISSUE;
                        d.beat = q.beat + BW'(1);
                        d.addr = q.addr + step_d;
                    end else begin
                        d.st = S_IDLE;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ta_n   <= 1'b1;
            q.tea_n  <= 1'b1;
            q.rtry_n <= 1'b1;
            q.irq_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sb_req = (q.st == S_WAIT);
    assign sb_we  = !q.rd;
    assign addr_q = q.addr;
    assign hin_q  = q.hin;
    assign hout_q = q.hout;
    assign ta_n   = q.ta_n;
    assign tea_n  = q.tea_n;
    assign rtry_n = q.rtry_n;
    assign irq_n  = q.irq_n;
    assign oe     = q.oe;

    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |=> ta_n);

    p_resp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ta_n, !tea_n, !rtry_n}));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_req && !sb_ack && !sb_err && !sb_retry) |=> (sb_req && $stable(addr_q)));

    p_no_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && (ts_n || cs0_n || !cs1)) |=> (!sb_req && ta_n));

    p_err_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_req && (sb_err || sb_retry)) |=> !sb_req);

    p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_n == !$past(irq_src)));

endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
    import hbus_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_width,
    input  logic            cfg_par_en,
    input  logic            hb_cs0_n,
    input  logic            hb_cs1,
    input  logic            hb_ts_n,
    input  logic            hb_rw,
    input  logic            hb_burst_n,
    input  logic            hb_bdip_n,
    input  logic [AW-1:0]   hb_addr,
    input  logic [DW-1:0]   hb_data_i,
    input  logic [DW/8-1:0] hb_par_i,
    output logic [DW-1:0]   hb_data_o,
    output logic [DW/8-1:0] hb_par_o,
    output logic            hb_data_oe,
    output logic            hb_ta_n,
    output logic            hb_tea_n,
    output logic            hb_rtry_n,
    output logic            hb_irq_n,
    input  logic            irq_src,
    output logic            sb_req,
    output logic            sb_we,
    output logic [AW-1:0]   sb_addr,
    output logic [DW/8-1:0] sb_be,
    output logic [DW-1:0]   sb_wdata,
    input  logic [DW-1:0]   sb_rdata,
    input  logic            sb_ack,
    input  logic            sb_err,
    input  logic            sb_retry
);
    wmode_e        width;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] hin_q;
    logic [DW-1:0] host_rd;
    logic          perr_now;

    assign width = eff_width(cfg_width);

    hbus_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .width    (width),
        .ts_n     (hb_ts_n),
        .cs0_n    (hb_cs0_n),
        .cs1      (hb_cs1),
        .rw       (hb_rw),
        .burst_n  (hb_burst_n),
        .bdip_n   (hb_bdip_n),
        .addr_i   (hb_addr),
        .hd_i     (hb_data_i),
        .perr_now (perr_now),
        .host_rd  (host_rd),
        .irq_src  (irq_src),
        .sb_ack   (sb_ack),
        .sb_err   (sb_err),
        .sb_retry (sb_retry),
        .sb_req   (sb_req),
        .sb_we    (sb_we),
        .addr_q   (addr_q),
        .hin_q    (hin_q),
        .hout_q   (hb_data_o),
        .ta_n     (hb_ta_n),
        .tea_n    (hb_tea_n),
        .rtry_n   (hb_rtry_n),
        .irq_n    (hb_irq_n),
        .oe       (hb_data_oe)
    );

    hbus_lanes #(.DW(DW)) lanes_i (
        .width    (width),
        .par_en   (cfg_par_en),
        .lane_sel (addr_q[1:0]),
        .hin      (hin_q),
        .sb_wdata (sb_wdata),
        .sb_be    (sb_be),
        .sb_rdata (sb_rdata),
        .host_rd  (host_rd),
        .hd_i     (hb_data_i),
        .hp_i     (hb_par_i),
        .perr_now (perr_now),
        .hout     (hb_data_o),
        .hp_o     (hb_par_o)
    );

    assign sb_addr = {addr_q[AW-1:2], 2'b00};

    p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req |-> ((sb_be != '0) && (width != W8 || $countones(sb_be) == 1)));

    p_oe_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hb_data_oe |-> !hb_ta_n);

endmodule

// File: tb/hbus_bridge_tb_top.sv
module hbus_bridge_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        we;
        logic [17:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd2;
    logic        cfg_par_en = 1'b1;
    logic        cs0_n = 1'b1, cs1 = 1'b0, ts_n = 1'b1, rw = 1'b1;
    logic        burst_n = 1'b1, bdip_n = 1'b1;
    logic [17:0] haddr = '0;
    logic [31:0] hdi = '0;
    logic [3:0]  hpi = '0;
    logic [31:0] hdo;
    logic [3:0]  hpo;
    logic        hoe, ta_n, tea_n, rtry_n, irq_n;
    logic        irq_src = 1'b0;
    logic        sb_req, sb_we;
    logic [17:0] sb_addr;
    logic [3:0]  sb_be;
    logic [31:0] sb_wdata, sb_rdata;
    logic        force_err = 1'b0, force_rty = 1'b0;
    logic        sb_ack, sb_err, sb_retry;
    logic [31:0] mem [16];

    int    n_checks = 0;
    int    n_err = 0;
    item_t exp_q[$];
    logic [31:0] wb [4];
    logic [31:0] rb [4];
    logic [3:0]  rp [4];
    logic        ro [4];
    int    nack, ntea, nrty;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sb_err   = sb_req & force_err;
    assign sb_retry = sb_req & ~force_err & force_rty;
    assign sb_ack   = sb_req & ~force_err & ~force_rty;
    assign sb_rdata = mem[sb_addr[5:2]];

    hbus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_par_en(cfg_par_en),
        .hb_cs0_n(cs0_n), .hb_cs1(cs1), .hb_ts_n(ts_n), .hb_rw(rw),
        .hb_burst_n(burst_n), .hb_bdip_n(bdip_n), .hb_addr(haddr),
        .hb_data_i(hdi), .hb_par_i(hpi), .hb_data_o(hdo), .hb_par_o(hpo),
        .hb_data_oe(hoe), .hb_ta_n(ta_n), .hb_tea_n(tea_n), .hb_rtry_n(rtry_n),
        .hb_irq_n(irq_n), .irq_src(irq_src), .sb_req(sb_req), .sb_we(sb_we),
        .sb_addr(sb_addr), .sb_be(sb_be), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata),
        .sb_ack(sb_ack), .sb_err(sb_err), .sb_retry(sb_retry)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] par4(input logic [31:0] v);
        return {^v[31:24], ^v[23:16], ^v[15:8], ^v[7:0]};
    endfunction

    // expected internal beat for host data at host address a under width w
    function automatic item_t mk(input logic we, input logic [17:0] a, input logic [31:0] hd, input logic [1:0] w);
        item_t it;
        it.we = we;
        it.addr = {a[17:2], 2'b00};
        case (w)
            2'd0: begin it.be = 4'b0001 << a[1:0]; it.data = {24'd0, hd[7:0]} << (8 * a[1:0]); end
            2'd1: begin it.be = a[1] ? 4'b1100 : 4'b0011; it.data = {16'd0, hd[15:0]} << (16 * a[1]); end
            default: begin it.be = 4'hF; it.data = hd; end
        endcase
        return it;
    endfunction

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    // scoreboard monitor and simple internal slave
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if (sb_req && (sb_ack || sb_err || sb_retry)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R6 unexpected internal request", {14'd0, sb_addr}, 32'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(sb_we == e.we, "R2 sb_we", {31'd0, sb_we}, {31'd0, e.we});
                check(sb_addr == e.addr, "R2/R5 sb_addr", {14'd0, sb_addr}, {14'd0, e.addr});
                if (e.we) begin
                    check(sb_be == e.be, "R2 sb_be", {28'd0, sb_be}, {28'd0, e.be});
                    check((sb_wdata & bmask(e.be)) == e.data, "R2 sb_wdata",
                          sb_wdata & bmask(e.be), e.data);
                end
            end
            if (sb_ack && sb_we) begin
                for (int b = 0; b < 4; b++)
                    if (sb_be[b]) mem[sb_addr[5:2]][8*b +: 8] <= sb_wdata[8*b +: 8];
            end
        end
    end

    task automatic xfer(input bit rd, input logic [17:0] a, input bit bst,
                        input int stop_after, input bit bad_par);
        int beat = 0;
        int lowc = 0;
        int cyc = 0;
        bit done = 0;
        nack = 0; ntea = 0; nrty = 0;
        @(negedge clk);
        cs0_n = 1'b0; cs1 = 1'b1; rw = rd; haddr = a;
        burst_n = !bst; bdip_n = !bst; ts_n = 1'b0;
        hdi = wb[0]; hpi = par4(wb[0]) ^ {3'b0, bad_par};
        @(negedge clk);
        ts_n = 1'b1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (!ta_n) begin
                lowc++;
                rb[beat] = hdo; rp[beat] = hpo; ro[beat] = hoe;
                nack++;
                beat++;
                if (bst && beat < 4 && beat < stop_after) begin
                    hdi = wb[beat]; hpi = par4(wb[beat]);
                end else begin
                    bdip_n = 1'b1;
                    done = 1;
                end
            end else if (!tea_n) begin
                ntea++; done = 1; bdip_n = 1'b1;
            end else if (!rtry_n) begin
                nrty++; done = 1; bdip_n = 1'b1;
            end
        end
        check(done, "watchdog transfer completion", cyc, 60);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!ta_n) lowc++;
        end
        check(lowc == nack, "R4 one-cycle acknowledge", lowc, nack);
        cs0_n = 1'b1; cs1 = 1'b0;
    endtask

    initial begin
        int wd;
        repeat (3) @(negedge clk);
        check(ta_n && tea_n && rtry_n && irq_n && !sb_req && !hoe, "R12 reset state",
              {26'd0, ta_n, tea_n, rtry_n, irq_n, sb_req, hoe}, 32'b111100);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: wrong chip-select combinations
        for (int c = 0; c < 2; c++) begin
            cs0_n = (c == 0); cs1 = (c == 0) ? 1'b1 : 1'b0; ts_n = 1'b0; rw = 1'b0;
            @(negedge clk); ts_n = 1'b1; wd = 0;
            repeat (6) begin @(negedge clk); if (!ta_n || sb_req) wd++; end
            check(wd == 0, "R1 deselected start ignored", wd, 0);
        end
        cs0_n = 1'b1; cs1 = 1'b0;

        // R2/R3: 32-bit single write and read
        cfg_width = 2'd2;
        wb[0] = 32'hA5A5_1234; exp_q.push_back(mk(1'b0 ? 1'b0 : 1'b1, 18'h10, wb[0], 2'd2));
        xfer(0, 18'h10, 0, 1, 0);
        check(nack == 1, "R2 write acknowledged", nack, 1);
        exp_q.push_back(mk(1'b0, 18'h10, 0, 2'd2));
        xfer(1, 18'h10, 0, 1, 0);
        check(rb[0] == 32'hA5A5_1234, "R3 32-bit read data", rb[0], 32'hA5A5_1234);
        check(ro[0] == 1'b1, "R3 data enable with ack", ro[0], 1);
        check(rp[0] == par4(32'hA5A5_1234), "R9 32-bit read parity", rp[0], par4(32'hA5A5_1234));

        // 8-bit lane steering
        cfg_width = 2'd0;
        wb[0] = 32'h0000_005C; exp_q.push_back(mk(1'b1, 18'h11, wb[0], 2'd0));
        xfer(0, 18'h11, 0, 1, 0);
        exp_q.push_back(mk(1'b0, 18'h11, 0, 2'd0));
        xfer(1, 18'h11, 0, 1, 0);
        check(rb[0] == 32'h5C, "R3 8-bit read lane 1", rb[0], 32'h5C);
        check(rp[0] == {3'b0, ^8'h5C}, "R9 8-bit parity one lane", rp[0], {3'b0, ^8'h5C});

        // 16-bit lane steering
        cfg_width = 2'd1;
        wb[0] = 32'h0000_BEEF; exp_q.push_back(mk(1'b1, 18'h12, wb[0], 2'd1));
        xfer(0, 18'h12, 0, 1, 0);
        exp_q.push_back(mk(1'b0, 18'h12, 0, 2'd1));
        xfer(1, 18'h12, 0, 1, 0);
        check(rb[0] == 32'hBEEF, "R3 16-bit read upper half", rb[0], 32'hBEEF);
        cfg_width = 2'd2;
        exp_q.push_back(mk(1'b0, 18'h10, 0, 2'd2));
        xfer(1, 18'h10, 0, 1, 0);
        check(rb[0] == 32'hBEEF_5C34, "R2 merged narrow writes", rb[0], 32'hBEEF_5C34);

        // R5: 32-bit burst write and read
        for (int i = 0; i < 4; i++) begin
            wb[i] = 32'h0302_0100 + 32'h0404_0404 * i;
            exp_q.push_back(mk(1'b1, 18'h20 + 18'(4 * i), wb[i], 2'd2));
        end
        xfer(0, 18'h20, 1, 4, 0);
        check(nack == 4, "R5 burst write beats", nack, 4);
        for (int i = 0; i < 4; i++) exp_q.push_back(mk(1'b0, 18'h20 + 18'(4 * i), 0, 2'd2));
        xfer(1, 18'h20, 1, 4, 0);
        check(nack == 4, "R5 burst read beats", nack, 4);
        for (int i = 0; i < 4; i++)
            check(rb[i] == 32'h0302_0100 + 32'h0404_0404 * i, "R5 burst read data", rb[i],
                  32'h0302_0100 + 32'h0404_0404 * i);

        // R5: 8-bit burst read steps by one byte
        cfg_width = 2'd0;
        for (int i = 0; i < 4; i++) exp_q.push_back(mk(1'b0, 18'h24 + 18'(i), 0, 2'd0));
        xfer(1, 18'h24, 1, 4, 0);
        for (int i = 0; i < 4; i++)
            check(rb[i] == 32'(8'h04 + i), "R5 8-bit burst bytes", rb[i], 32'(8'h04 + i));

        // R6: abort after two beats
        cfg_width = 2'd2;
        for (int i = 0; i < 2; i++) exp_q.push_back(mk(1'b0, 18'h20 + 18'(4 * i), 0, 2'd2));
        xfer(1, 18'h20, 1, 2, 0);
        check(nack == 2, "R6 aborted burst beats", nack, 2);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 no further requests", exp_q.size(), 0);

        // R7: internal error, single and burst
        force_err = 1'b1;
        wb[0] = 32'h1; exp_q.push_back(mk(1'b1, 18'h30, wb[0], 2'd2));
        xfer(0, 18'h30, 0, 1, 0);
        check(ntea == 1 && nack == 0, "R7 error instead of ack", {ntea[15:0], nack[15:0]}, 32'h0001_0000);
        exp_q.push_back(mk(1'b0, 18'h20, 0, 2'd2));
        xfer(1, 18'h20, 1, 4, 0);
        check(ntea == 1 && nack == 0, "R7 burst ends on error", {ntea[15:0], nack[15:0]}, 32'h0001_0000);
        force_err = 1'b0;

        // R8: retry
        force_rty = 1'b1;
        exp_q.push_back(mk(1'b0, 18'h20, 0, 2'd2));
        xfer(1, 18'h20, 0, 1, 0);
        check(nrty == 1 && nack == 0 && ntea == 0, "R8 retry pulse", {nrty[15:0], nack[15:0]}, 32'h0001_0000);
        force_rty = 1'b0;

        // R9: parity off
        cfg_par_en = 1'b0;
        exp_q.push_back(mk(1'b0, 18'h10, 0, 2'd2));
        xfer(1, 18'h10, 0, 1, 0);
        check(rp[0] == 4'd0, "R9 parity disabled", rp[0], 0);

        // R10: sticky parity flag
        wb[0] = 32'h0000_0001; exp_q.push_back(mk(1'b1, 18'h14, wb[0], 2'd2));
        xfer(0, 18'h14, 0, 1, 1);
        xfer(1, 18'h3FFFC, 0, 1, 0);
        check(rb[0][0] == 1'b0, "R10 no flag with parity off", rb[0][0], 0);
        cfg_par_en = 1'b1;
        exp_q.push_back(mk(1'b1, 18'h14, wb[0], 2'd2));
        xfer(0, 18'h14, 0, 1, 1);
        xfer(1, 18'h3FFFC, 0, 1, 0);
        check(rb[0][0] == 1'b1, "R10 flag set by bad parity", rb[0][0], 1);
        check(rb[0][15:8] == rb[0][7:0], "R10 status in every lane", rb[0][15:8], rb[0][7:0]);
        wb[0] = 32'h0000_0001;
        xfer(0, 18'h3FFFC, 0, 1, 0);
        xfer(1, 18'h3FFFC, 0, 1, 0);
        check(rb[0][0] == 1'b0, "R10 flag cleared", rb[0][0], 0);

        // R11: interrupt
        @(negedge clk); irq_src = 1'b1;
        @(negedge clk);
        check(irq_n == 1'b0, "R11 irq asserted", irq_n, 0);
        xfer(1, 18'h3FFFC, 0, 1, 0);
        check(rb[0][1] == 1'b1, "R11 status shows source", rb[0][1], 1);
        irq_src = 1'b0;
        @(negedge clk);
        check(irq_n == 1'b1, "R11 irq released", irq_n, 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule